// File: doc/BRIEF.md
# Addressing Mode Operand Fetch Unit

This block finds the operand for a load into a single accumulator. It accepts a 4-bit mode code, an instruction field that holds either an address or a literal, the program counter, the index register and the current value of one selected general register. It forms the operand address, reads memory once or twice as needed, and delivers the loaded word on a registered accumulator output. A one-cycle done pulse marks that delivery.

Memory is word-addressed and synchronous. The unit raises a request with an address and holds both until the memory returns valid together with the read data. In the pointer modes the unit also produces a write-back to the selected register: it moves the pointer one word up after the read, or one word down before it. A start pulse begins an operation. Start pulses that arrive while a memory operation is in progress are ignored. Mode codes outside the defined set produce a one-cycle illegal flag and change nothing.

Top module: `opf_unit`

## Requirements
- R1: Mode code 0 (direct) reads memory at the field value and loads that word into the accumulator.
- R2: Mode code 1 (memory-indirect) makes two reads. The first is at the field value. The word it returns is the address of the second read, and the second word is loaded into the accumulator.
- R3: Mode code 2 (relative) reads memory at PC + field, modulo 2^16.
- R4: Mode code 3 (immediate) loads the field into the accumulator with no memory request. Done rises in the cycle after start.
- R5: Mode code 4 (indexed) reads memory at field + index register, modulo 2^16.
- R6: Mode code 5 (register) loads the selected register value with no memory request. Done rises in the cycle after start.
- R7: Mode code 6 (register-indirect) reads memory at the selected register value and makes no register write-back.
- R8: Mode code 7 (post-increment) reads at the register value. It then writes register + 1 (mod 2^16) back exactly once, in the same cycle as done.
- R9: Mode code 8 (pre-decrement) writes register − 1 (mod 2^16) back exactly once, in the cycle the first request rises. It then reads at that decremented address.
- R10: A memory request, together with its address, stays asserted and unchanged until valid is returned. Memory modes raise the request in the cycle after start.
- R11: Mode codes 9 to 15 pulse the illegal flag for one cycle, in the cycle after start. They produce no request, no done and no register write, and the accumulator keeps its value.
- R12: Done lasts exactly one cycle. The accumulator changes only in a cycle where done is high.
- R13: After reset, request, done, the illegal flag and register write are low, and the accumulator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins an operand fetch; operands are sampled in the same cycle |
| mode_i | input | 4 | Addressing mode code |
| field_i | input | 16 | Address or literal field of the instruction |
| pc_i | input | 16 | Program counter value |
| xr_i | input | 16 | Index register value |
| reg_i | input | 16 | Value of the selected general register |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_valid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 16 | Memory read data |
| acc_o | output | 16 | Accumulator value |
| done_o | output | 1 | One-cycle pulse when the accumulator is written |
| illegal_o | output | 1 | One-cycle pulse for an undefined mode code |
| reg_we_o | output | 1 | Write-back strobe for the selected register |
| reg_wdata_o | output | 16 | New value for the selected register |

## Verification
The bench targets four kinds of corner case.
- Address wrap-around in relative and indexed modes, and in the pointer modes at 0x0000 and 0xFFFF. A design that carries into a 17th bit, or that fails to wrap, reads the wrong word.
- The ordering of the pointer write-back. A design that swaps pre- and post-update reads the neighbouring word, or strobes the register at the wrong time.
- The second read of memory-indirect mode. A design that skips it loads the pointer instead of the data.
- The random memory latency. A design that drops its request early, or that changes the address early, hangs or loads stale data.
Undefined mode codes are mixed into the random stream. A design that treats them as a real mode would pulse done or move the accumulator.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_DIRECT   = 4'd0,
    AM_INDIRECT = 4'd1,
    AM_RELATIVE = 4'd2,
    AM_IMMED    = 4'd3,
    AM_INDEXED  = 4'd4,
    AM_REGISTER = 4'd5,
    AM_REGIND   = 4'd6,
    AM_POSTINC  = 4'd7,
    AM_PREDEC   = 4'd8
  } am_mode_e;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } opf_state_e;
endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
  import opf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      field_i,
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      xr_i,
  input  logic [W-1:0]      reg_i,
  output logic [W-1:0]      ea_o,
  output logic [W-1:0]      lit_o,
  output logic [W-1:0]      ptr_next_o,
  output logic              legal_o,
  output logic              uses_mem_o,
  output logic              two_step_o,
  output logic              pre_upd_o,
  output logic              post_upd_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    ea_o       = field_i;
    lit_o      = field_i;
    ptr_next_o = reg_i;
    legal_o    = 1'b1;
    uses_mem_o = 1'b1;
    two_step_o = 1'b0;
    pre_upd_o  = 1'b0;
    post_upd_o = 1'b0;
    case (mode_i)
      AM_DIRECT:   ea_o = field_i;
      AM_INDIRECT: begin
        ea_o       = field_i;
        two_step_o = 1'b1;
      end
      AM_RELATIVE: ea_o = pc_i + field_i;
      AM_IMMED: begin
        uses_mem_o = 1'b0;
        lit_o      = field_i;
      end
      AM_INDEXED:  ea_o = field_i + xr_i;
      AM_REGISTER: begin
        uses_mem_o = 1'b0;
        lit_o      = reg_i;
      end
      AM_REGIND:   ea_o = reg_i;
      AM_POSTINC: begin
        ea_o       = reg_i;
        ptr_next_o = reg_i + ONE;
        post_upd_o = 1'b1;
      end
      AM_PREDEC: begin
        ea_o       = reg_i - ONE;
        ptr_next_o = reg_i - ONE;
        pre_upd_o  = 1'b1;
      end
      default: begin
        legal_o    = 1'b0;
        uses_mem_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] ea_i,
  input  logic [W-1:0] lit_i,
  input  logic [W-1:0] ptr_next_i,
  input  logic         legal_i,
  input  logic         uses_mem_i,
  input  logic         two_step_i,
  input  logic         pre_upd_i,
  input  logic         post_upd_i,
  input  logic         mem_valid_i,
  input  logic [W-1:0] mem_rdata_i,
  output logic         mem_req_o,
  output logic [W-1:0] mem_addr_o,
  output logic         illegal_o,
  output logic         busy_o,
  output logic         ld_en_o,
  output logic [W-1:0] ld_val_o,
  output logic         upd_en_o,
  output logic [W-1:0] upd_val_o
);
  opf_state_e   state_q;
  logic         indir_q;
  logic         post_q;
  logic [W-1:0] ptr_q;
  logic         accept;
  logic         beat;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign beat   = (state_q == ST_FETCH) && mem_req_o && mem_valid_i;
  assign busy_o = (state_q == ST_FETCH);

  always_comb begin
    ld_en_o   = 1'b0;
    ld_val_o  = mem_rdata_i;
    upd_en_o  = 1'b0;
    upd_val_o = ptr_q;
    if (accept && legal_i) begin
      if (!uses_mem_i) begin
        ld_en_o  = 1'b1;
        ld_val_o = lit_i;
      end
      if (pre_upd_i) begin
        upd_en_o  = 1'b1;
        upd_val_o = ptr_next_i;
      end
    end else if (beat && !indir_q) begin
      ld_en_o = 1'b1;
      if (post_q) upd_en_o = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      illegal_o  <= 1'b0;
      indir_q    <= 1'b0;
      post_q     <= 1'b0;
      ptr_q      <= '0;
    end else begin
      illegal_o <= 1'b0;
      if (accept) begin
        if (!legal_i) begin
          illegal_o <= 1'b1;
        end else if (uses_mem_i) begin
          state_q    <= ST_FETCH;
          mem_req_o  <= 1'b1;
          mem_addr_o <= ea_i;
          indir_q    <= two_step_i;
          post_q     <= post_upd_i;
          ptr_q      <= ptr_next_i;
        end
      end else if (beat) begin
        if (indir_q) begin
          mem_addr_o <= mem_rdata_i;
          indir_q    <= 1'b0;
        end else begin
          mem_req_o <= 1'b0;
          post_q    <= 1'b0;
          state_q   <= ST_IDLE;
        end
      end
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_req_follows_start_r10: assert property (@(posedge clk) disable iff (rst)
    (accept && legal_i && uses_mem_i) |=> (mem_req_o && mem_addr_o == $past(ea_i)));

  p_illegal_no_req_r11: assert property (@(posedge clk) disable iff (rst)
    (accept && !legal_i) |=> (illegal_o && !mem_req_o));

  p_req_only_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);
endmodule

// File: rtl/opf_wb.sv
module opf_wb #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         upd_en_i,
  input  logic [W-1:0] upd_val_i,
  output logic [W-1:0] acc_o,
  output logic         done_o,
  output logic         reg_we_o,
  output logic [W-1:0] reg_wdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o       <= '0;
      done_o      <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      done_o   <= ld_en_i;
      reg_we_o <= upd_en_i;
      if (ld_en_i)  acc_o       <= ld_val_i;
      if (upd_en_i) reg_wdata_o <= upd_val_i;
    end
  end

  p_acc_moves_with_done_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(acc_o) |-> done_o);

  p_load_gives_done_r12: assert property (@(posedge clk) disable iff (rst)
    ld_en_i |=> (done_o && acc_o == $past(ld_val_i)));
endmodule

// File: rtl/opf_unit.sv
module opf_unit
  import opf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      field_i,
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      xr_i,
  input  logic [W-1:0]      reg_i,
  output logic              mem_req_o,
  output logic [W-1:0]      mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [W-1:0]      mem_rdata_i,
  output logic [W-1:0]      acc_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              reg_we_o,
  output logic [W-1:0]      reg_wdata_o
);
  logic [W-1:0] ea, lit, ptr_next, ld_val, upd_val;
  logic         legal, uses_mem, two_step, pre_upd, post_upd;
  logic         busy, ld_en, upd_en;

  opf_ea_calc #(.W(W)) u_ea (
    .mode_i     (mode_i),
    .field_i    (field_i),
    .pc_i       (pc_i),
    .xr_i       (xr_i),
    .reg_i      (reg_i),
    .ea_o       (ea),
    .lit_o      (lit),
    .ptr_next_o (ptr_next),
    .legal_o    (legal),
    .uses_mem_o (uses_mem),
    .two_step_o (two_step),
    .pre_upd_o  (pre_upd),
    .post_upd_o (post_upd)
  );

  opf_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .ea_i        (ea),
    .lit_i       (lit),
    .ptr_next_i  (ptr_next),
    .legal_i     (legal),
    .uses_mem_i  (uses_mem),
    .two_step_i  (two_step),
    .pre_upd_i   (pre_upd),
    .post_upd_i  (post_upd),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .illegal_o   (illegal_o),
    .busy_o      (busy),
    .ld_en_o     (ld_en),
    .ld_val_o    (ld_val),
    .upd_en_o    (upd_en),
    .upd_val_o   (upd_val)
  );

  opf_wb #(.W(W)) u_wb (
    .clk         (clk),
    .rst         (rst),
    .ld_en_i     (ld_en),
    .ld_val_i    (ld_val),
    .upd_en_i    (upd_en),
    .upd_val_i   (upd_val),
    .acc_o       (acc_o),
    .done_o      (done_o),
    .reg_we_o    (reg_we_o),
    .reg_wdata_o (reg_wdata_o)
  );

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!done_o && !mem_req_o && !reg_we_o));

  p_immediate_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && mode_i == AM_IMMED) |=>
      (done_o && !mem_req_o && acc_o == $past(field_i)));

  p_predec_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_we_o && mem_req_o) |-> (mem_addr_o == reg_wdata_o));

  p_postinc_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_we_o && !mem_req_o) |-> done_o);
endmodule

// File: tb/opf_unit_test.sv
module opf_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [15:0] field_i = '0, pc_i = '0, xr_i = '0, reg_i = '0;
  logic        mem_req_o, mem_valid_i;
  logic [15:0] mem_addr_o, mem_rdata_i, acc_o, reg_wdata_o;
  logic        done_o, illegal_o, reg_we_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  opf_unit uut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .field_i(field_i), .pc_i(pc_i), .xr_i(xr_i), .reg_i(reg_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
    .acc_o(acc_o), .done_o(done_o), .illegal_o(illegal_o),
    .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    logic [15:0] t;
    logic [31:0] p;
    t = a ^ 16'h3c5a;
    p = t * 32'd40503 + 32'd7;
    return p[15:0];
  endfunction

  // memory model with random latency
  int cnt = 0;
  int lat = 1;
  always @(posedge clk) begin
    if (rst) begin
      mem_valid_i <= 1'b0;
      mem_rdata_i <= '0;
      cnt <= 0;
    end else if (mem_valid_i) begin
      mem_valid_i <= 1'b0;
      cnt <= 0;
      lat <= int'($urandom % 4);
    end else if (mem_req_o) begin
      if (cnt >= lat) begin
        mem_valid_i <= 1'b1;
        mem_rdata_i <= memf(mem_addr_o);
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_acc(input logic [3:0] m, input logic [15:0] f, p, x, r);
    case (m)
      4'd0: return memf(f);
      4'd1: return memf(memf(f));
      4'd2: return memf(p + f);
      4'd3: return f;
      4'd4: return memf(f + x);
      4'd5: return r;
      4'd6: return memf(r);
      4'd7: return memf(r);
      4'd8: return memf(r - 16'd1);
      default: return 16'h0;
    endcase
  endfunction

  function automatic int exp_reads(input logic [3:0] m);
    if (m == 4'd1) return 2;
    if (m == 4'd3 || m == 4'd5 || m > 4'd8) return 0;
    return 1;
  endfunction

  function automatic string rtag(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] m, input logic [15:0] f, p, x, r);
    logic [15:0] acc_before;
    int reads = 0, we_cnt = 0, cycles = 0, first_req_cyc = -1, we_cyc = -1;
    bit saw_done = 0, saw_ill = 0, we_with_done = 0, we_with_req = 0, stuck = 1;
    logic [15:0] we_val = '0;
    string t;
    t = rtag(m);
    @(negedge clk);
    acc_before = acc_o;
    mode_i = m; field_i = f; pc_i = p; xr_i = x; reg_i = r; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 100; c++) begin
      if (mem_req_o && first_req_cyc < 0) first_req_cyc = c;
      if (mem_req_o && mem_valid_i) reads++;
      if (reg_we_o) begin
        we_cnt++; we_val = reg_wdata_o; we_cyc = c;
        we_with_done = done_o; we_with_req = mem_req_o;
      end
      if (done_o) saw_done = 1;
      if (illegal_o) saw_ill = 1;
      cycles = c;
      if (done_o || illegal_o) begin stuck = 0; break; end
      @(negedge clk);
    end
    if (m > 4'd8) begin
      chk(saw_ill && !saw_done, "R11 illegal flag without done", {30'd0, saw_ill, saw_done}, 32'h2);
      chk(cycles == 0, "R11 illegal flag one cycle after start", cycles, 0);
      chk(acc_o == acc_before, "R11 accumulator unchanged", acc_o, acc_before);
      chk(we_cnt == 0 && reads == 0 && first_req_cyc < 0, "R11 no request and no register write", we_cnt + reads, 0);
      @(negedge clk);
      chk(!illegal_o && !done_o, "R11 illegal flag single cycle", illegal_o, 0);
      return;
    end
    chk(!stuck && saw_done, {t, " done reached"}, saw_done, 1);
    chk(acc_o == exp_acc(m, f, p, x, r), {t, " accumulator value"}, acc_o, exp_acc(m, f, p, x, r));
    chk(reads == exp_reads(m), {t, " number of memory reads"}, reads, exp_reads(m));
    if (exp_reads(m) == 0)
      chk(cycles == 0, {t, " done in cycle after start"}, cycles, 0);
    else
      chk(first_req_cyc == 0, "R10 request in cycle after start", first_req_cyc, 0);
    if (m == 4'd7) begin
      chk(we_cnt == 1 && we_val == r + 16'd1, "R8 register write-back value", we_val, r + 16'd1);
      chk(we_with_done && !we_with_req, "R8 write-back with done", we_with_done, 1);
    end else if (m == 4'd8) begin
      chk(we_cnt == 1 && we_val == r - 16'd1, "R9 register write-back value", we_val, r - 16'd1);
      chk(we_cyc == first_req_cyc && we_with_req, "R9 write-back when request rises", we_cyc, first_req_cyc);
    end else begin
      chk(we_cnt == 0, {t, " no register write-back (R7)"}, we_cnt, 0);
    end
    @(negedge clk);
    chk(!done_o && !mem_req_o, "R12 done single cycle", done_o, 0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req_o && !done_o && !illegal_o && !reg_we_o && acc_o == 16'h0,
        "R13 reset state", {mem_req_o, done_o, illegal_o, reg_we_o}, 0);

    // directed corner cases
    run_op(4'd0, 16'h1234, 16'h0, 16'h0, 16'h0);
    run_op(4'd1, 16'h00ff, 16'h0, 16'h0, 16'h0);
    run_op(4'd2, 16'h0020, 16'hfff0, 16'h0, 16'h0);
    run_op(4'd3, 16'hbeef, 16'h0, 16'h0, 16'h0);
    run_op(4'd4, 16'hff00, 16'h0, 16'h0200, 16'h0);
    run_op(4'd5, 16'h0, 16'h0, 16'h0, 16'hcafe);
    run_op(4'd6, 16'h0, 16'h0, 16'h0, 16'h4321);
    run_op(4'd7, 16'h0, 16'h0, 16'h0, 16'hffff);
    run_op(4'd8, 16'h0, 16'h0, 16'h0, 16'h0000);
    run_op(4'd9, 16'h1111, 16'h0, 16'h0, 16'h0);
    run_op(4'd15, 16'h2222, 16'h0, 16'h0, 16'h0);

    // busy start ignored: second start during a memory fetch
    @(negedge clk);
    mode_i = 4'd0; field_i = 16'h0042; start_i = 1'b1;
    @(negedge clk);
    mode_i = 4'd3; field_i = 16'h9999;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 100; c++) begin
      if (done_o) break;
      @(negedge clk);
    end
    chk(acc_o == memf(16'h0042), "R10 start during fetch ignored", acc_o, memf(16'h0042));
    repeat (2) @(negedge clk);
    chk(acc_o == memf(16'h0042) && !done_o, "R12 no extra done after ignored start", acc_o, memf(16'h0042));

    // random stream
    for (int i = 0; i < 400; i++) begin
      run_op(4'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule